// File: doc/BRIEF.md
# I2C Line Glitch Filter

This block sits between the pads and the protocol logic of an I2C controller. It removes short pulses from the incoming clock (SCL) and data (SDA) lines. Each raw line first passes through a two-stage synchronizer. A per-line counter then decides whether a change of level is real. The filtered output follows the input only after the new level has held for one cycle longer than a programmable limit. Any pulse that lasts no longer than the limit is discarded.

The limit sits in the low byte of a 32-bit register and counts cycles of the block clock. Software writes it through a simple write strobe and can read it back at any time. The register accepts writes only while the controller-enable input is low, and it never stores a limit of zero.

Top module: `i2c_glitch_filter`

## Requirements
- R1: `rd_data` always returns the stored limit in bits 7:0, and bits 31:8 always read as zero.
- R2: A synchronous reset (`rst` high at a clock edge) sets the limit to 2 and drives both `scl_filt` and `sda_filt` to 1.
- R3: A low pulse on a raw line that is sampled for at most `limit` consecutive clock edges causes no change on that line's filtered output.
- R4: A new level that is sampled for `limit + 1` consecutive edges reaches the filtered output. The output changes at the clock edge `limit + 3` edges after the first edge that samples the new raw level: two edges for the synchronizer and `limit + 1` edges for the filter.
- R5: A write of 0 in bits 7:0, accepted while disabled, stores a limit of 1.
- R6: While `ctrl_enable` is 1, a `wr_en` pulse leaves the stored limit unchanged.
- R7: While `ctrl_enable` is 0, a `wr_en` pulse stores `wr_data[7:0]` (nonzero) at the next edge, and bits 31:8 of `wr_data` are ignored.
- R8: The SCL and SDA filters are independent: a pulse on one raw line never changes the other filtered output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all filtering is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Register write data; only bits 7:0 are used |
| ctrl_enable | input | 1 | Controller enable; high blocks register writes |
| rd_data | output | 32 | Register read-back value |
| scl_raw | input | 1 | Unsynchronized SCL from the pad |
| sda_raw | input | 1 | Unsynchronized SDA from the pad |
| scl_filt | output | 1 | Synchronized, glitch-free SCL |
| sda_filt | output | 1 | Synchronized, glitch-free SDA |

## Verification
A corrupted limit register shows on `rd_data` at the next edge, since the read path is combinational from the stored byte. A counter that is wrong or shared between lines shows only when a pulse sits exactly at the limit boundary. It then appears as a missing or extra pair of output toggles within `limit + 3` cycles of the pulse. The bench therefore drives pulses of exactly `limit` and `limit + 1` edges on each line, counts the toggles on both filtered outputs, and repeats this after every accepted or refused register change.

// File: rtl/i2c_gf_pkg.sv
package i2c_gf_pkg;
    localparam int GF_LIMIT_W    = 8;
    localparam int GF_REG_W      = 32;
    localparam int GF_SYNC_DEPTH = 2;
    localparam int GF_LIMIT_RST  = 2;
    localparam int GF_NUM_LINES  = 2;

    typedef enum logic [0:0] {
        LINE_SCL = 1'b0,
        LINE_SDA = 1'b1
    } gf_line_e;

    // Per-line filter state: accepted level plus run length of disagreement.
    typedef struct packed {
        logic                  level;
        logic [GF_LIMIT_W-1:0] run;
    } gf_state_t;

    function automatic logic [GF_LIMIT_W-1:0] gf_floor_one(input logic [GF_LIMIT_W-1:0] v);
        return (v == '0) ? GF_LIMIT_W'(1) : v;
    endfunction
endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int DEPTH     = 2,
    parameter bit RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {DEPTH{RST_LEVEL}};
        else     chain <= {chain[DEPTH-2:0], d};
    end

    assign q = chain[DEPTH-1];
endmodule

// File: rtl/gf_limit_reg.sv
module gf_limit_reg
    import i2c_gf_pkg::*;
#(
    parameter int LIMIT_W   = GF_LIMIT_W,
    parameter int REG_W     = GF_REG_W,
    parameter int LIMIT_RST = GF_LIMIT_RST
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               ctrl_enable,
    output logic [LIMIT_W-1:0] limit,
    output logic [REG_W-1:0]   rd_data
);
    localparam int PAD_W = REG_W - LIMIT_W;

    logic               accept;
    logic [LIMIT_W-1:0] next_val;

    assign accept   = wr_en && !ctrl_enable;
    assign next_val = (wr_data[LIMIT_W-1:0] == '0) ? LIMIT_W'(1) : wr_data[LIMIT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)         limit <= LIMIT_W'(LIMIT_RST);
        else if (accept) limit <= next_val;
    end

    assign rd_data = {{PAD_W{1'b0}}, limit};
endmodule

// File: rtl/gf_line_filter.sv
module gf_line_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] limit,
    input  logic             din,
    output logic             dout
);
    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] run;
    } state_t;

    state_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (din == cur.level) begin
            nxt.run = '0;
        end else if (cur.run >= limit) begin
            nxt.level = din;
            nxt.run   = '0;
        end else begin
            nxt.run = cur.run + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.level <= 1'b1;
            cur.run   <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign dout = cur.level;
endmodule

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter
    import i2c_gf_pkg::*;
#(
    parameter int LIMIT_W    = GF_LIMIT_W,
    parameter int REG_W      = GF_REG_W,
    parameter int SYNC_DEPTH = GF_SYNC_DEPTH,
    parameter int LIMIT_RST  = GF_LIMIT_RST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ctrl_enable,
    output logic [REG_W-1:0] rd_data,
    input  logic             scl_raw,
    input  logic             sda_raw,
    output logic             scl_filt,
    output logic             sda_filt
);
    localparam int NLINES = GF_NUM_LINES;

    logic [LIMIT_W-1:0] limit;
    logic [NLINES-1:0]  raw_vec, sync_vec, filt_vec;

    assign raw_vec[LINE_SCL] = scl_raw;
    assign raw_vec[LINE_SDA] = sda_raw;

    gf_limit_reg #(
        .LIMIT_W(LIMIT_W), .REG_W(REG_W), .LIMIT_RST(LIMIT_RST)
    ) u_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_enable(ctrl_enable), .limit(limit), .rd_data(rd_data)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        gf_sync #(.DEPTH(SYNC_DEPTH), .RST_LEVEL(1'b1)) u_sync (
            .clk(clk), .rst(rst), .d(raw_vec[i]), .q(sync_vec[i])
        );
        gf_line_filter #(.CNT_W(LIMIT_W)) u_filt (
            .clk(clk), .rst(rst), .limit(limit),
            .din(sync_vec[i]), .dout(filt_vec[i])
        );
    end

    assign scl_filt = filt_vec[LINE_SCL];
    assign sda_filt = filt_vec[LINE_SDA];
endmodule

// File: rtl/gf_checker.sv
module gf_checker #(
    parameter int LIMIT_W = 8,
    parameter int REG_W   = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             ctrl_enable,
    input logic [REG_W-1:0] rd_data,
    input logic             scl_filt,
    input logic             sda_filt
);
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-1:LIMIT_W] == '0);

    assert_never_zero_R5: assert property (@(posedge clk) disable iff (rst)
        rd_data[LIMIT_W-1:0] != '0);

    assert_locked_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl_enable |=> rd_data == $past(rd_data));

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ctrl_enable && wr_data[LIMIT_W-1:0] != '0)
            |=> rd_data[LIMIT_W-1:0] == $past(wr_data[LIMIT_W-1:0]));

    // Limit >= 1 means any accepted level lasts at least two cycles.
    assert_scl_min_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl_filt) |=> $stable(scl_filt));

    assert_sda_min_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_filt) |=> $stable(sda_filt));
endmodule

bind i2c_glitch_filter gf_checker #(.LIMIT_W(LIMIT_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/tb_i2c_glitch_filter.sv
`timescale 1ns/1ps
module tb_i2c_glitch_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ctrl_enable = 1'b0;
    logic [31:0] rd_data;
    logic        scl_raw = 1'b1, sda_raw = 1'b1;
    logic        scl_filt, sda_filt;

    always #2.5 clk = ~clk;

    i2c_glitch_filter dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_enable(ctrl_enable), .rd_data(rd_data),
        .scl_raw(scl_raw), .sda_raw(sda_raw),
        .scl_filt(scl_filt), .sda_filt(sda_filt)
    );

    typedef struct {
        string tag;
        int    line;
        int    exp_toggles;
    } sb_item_t;

    sb_item_t sb[$];
    int n_checks = 0, n_err = 0;
    int req_cnt = 0, done_cnt = 0;
    int cur_limit = 2;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    // Monitor: counts toggles on each filtered line, scores on request.
    initial begin
        int  tog [2];
        logic prev [2];
        tog[0] = 0; tog[1] = 0;
        prev[0] = 1'b1; prev[1] = 1'b1;
        forever begin
            @(negedge clk);
            if (scl_filt !== prev[0]) tog[0]++;
            if (sda_filt !== prev[1]) tog[1]++;
            prev[0] = scl_filt;
            prev[1] = sda_filt;
            if (req_cnt > done_cnt) begin
                while (sb.size() > 0) begin
                    sb_item_t it;
                    it = sb.pop_front();
                    check(it.tag, tog[it.line], it.exp_toggles);
                end
                tog[0] = 0; tog[1] = 0;
                done_cnt = req_cnt;
            end
        end
    end

    task automatic write_reg(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // Driver: low pulse of 'width' sampled edges on one line.
    task automatic pulse(input int line, input int width, input string tag);
        sb_item_t a, b;
        @(negedge clk);
        if (line == 0) scl_raw = 1'b0; else sda_raw = 1'b0;
        repeat (width) @(negedge clk);
        scl_raw = 1'b1; sda_raw = 1'b1;
        repeat (cur_limit + 10) @(negedge clk);
        a.tag = tag; a.line = line;     a.exp_toggles = (width > cur_limit) ? 2 : 0;
        b.tag = "R8 other line"; b.line = 1 - line; b.exp_toggles = 0;
        sb.push_back(a); sb.push_back(b);
        req_cnt++;
        wait (done_cnt == req_cnt);
    endtask

    task automatic boundary_pair();
        for (int ln = 0; ln < 2; ln++) begin
            pulse(ln, cur_limit,     "R3 pulse of limit rejected");
            pulse(ln, cur_limit + 1, "R4 pulse of limit+1 passes");
        end
    endtask

    // R4 latency: output falls exactly limit+3 edges after first sampled edge.
    task automatic latency_check();
        int edges;
        @(negedge clk);
        scl_raw = 1'b0;
        edges = 0;
        while (scl_filt === 1'b1 && edges < 300) begin
            @(negedge clk);
            edges++;
        end
        check("R4 latency edges", edges, cur_limit + 3);
        scl_raw = 1'b1;
        repeat (cur_limit + 10) @(negedge clk);
        req_cnt++;
        wait (done_cnt == req_cnt);
    endtask

    initial begin
        #(200000 * 5);
        check("watchdog expired", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 reset limit", int'(rd_data), 2);
        check("R2 reset scl_filt", int'(scl_filt), 1);
        check("R2 reset sda_filt", int'(sda_filt), 1);

        boundary_pair();
        latency_check();

        write_reg(32'h0);
        cur_limit = 1;
        check("R5 zero clamps to 1", int'(rd_data), 1);
        boundary_pair();

        write_reg(32'hFFFF_FF05);
        cur_limit = 5;
        check("R7 write stores low byte", int'(rd_data[7:0]), 5);
        check("R1 upper bits zero", int'(rd_data[31:8]), 0);
        boundary_pair();
        latency_check();

        ctrl_enable = 1'b1;
        write_reg(32'h0000_0009);
        check("R6 write while enabled ignored", int'(rd_data), 5);
        write_reg(32'h0000_0000);
        check("R6 zero write while enabled ignored", int'(rd_data), 5);
        boundary_pair();
        ctrl_enable = 1'b0;

        write_reg(32'h0000_00FF);
        cur_limit = 255;
        check("R7 max limit stored", int'(rd_data), 255);
        check("R1 read-back max", int'(rd_data[31:8]), 0);
        write_reg(32'h0000_0003);
        cur_limit = 3;
        check("R7 limit 3 stored", int'(rd_data), 3);
        boundary_pair();

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cur_limit = 2;
        check("R2 reset restores limit", int'(rd_data), 2);
        summary();
    end
endmodule